// File: doc/BRIEF.md
# Teletext Request and Capture Sequencer

This block fetches teletext bits from an external serial source and hands them to a downstream interpolation stage. The teletext bit rate does not divide evenly into the 27 MHz pixel clock: 37 bits must fit into every 144 clocks. A fractional accumulator paces a one-cycle request pulse so that most bits get four clocks and a few get three. The source answers each request on its serial data input a fixed four clocks later. The block delays its own request flags by the same amount and captures the input bit in exactly that cycle. It then emits the bit with a one-cycle strobe.

Requests are issued only while the encoder runs in the 625-line (PAL) standard, only on lines whose number falls inside a programmed first/last range, and only inside a horizontal window. The window opens a parameterized number of clocks after the line start and spans a whole number of 144-clock groups. On every line start the block compares the number of bits it requested during the line that just ended with the number it captured. If they differ, it raises a sticky error flag that stays set until reset.

Top module: `ttx_req_seq`

## Requirements
- R1: While and directly after reset, `ttx_req`, `bit_valid` and `count_err` are low.
- R2: Inside an enabled window, exactly 37 requests are issued per 144 clocks. Window clock index k counts from 0, where index 0 is the cycle with horizontal count H_START; the horizontal count is 0 in the cycle after the `line_start` cycle. The n-th request of a line (n from 1) is computed at index ceil(144n/37)-1 and is visible on `ttx_req` one cycle later, that is H_START+2+k cycles after the `line_start` cycle.
- R3: No request is issued on a line whose `line_num`, sampled with `line_start`, lies outside `first_line`..`last_line` (inclusive), and none is issued outside the window; a full line yields 37*GROUPS requests.
- R4: While `pal_mode` is low, no request is issued.
- R5: A request visible in cycle t captures `ttx_in` as present in cycle t+4; that value appears on `bit_data` with `bit_valid` high for one cycle in cycle t+5, and bits appear in request order.
- R6: At a `line_start`, if the count of requests in the ending line differs from the count of captures in it (for example when the line is cut short with a bit still in flight), `count_err` rises in the next cycle.
- R7: Lines long enough to drain every in-flight bit never set `count_err`.
- R8: Once set, `count_err` stays high through later complete lines until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_mode | input | 1 | High when the encoder runs the 625-line standard |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | LINE_W | Number of the starting line, valid with `line_start` |
| first_line | input | LINE_W | First line that carries teletext |
| last_line | input | LINE_W | Last line that carries teletext |
| ttx_req | output | 1 | One-cycle request to the teletext source |
| ttx_in | input | 1 | Serial teletext data, valid four clocks after a request |
| bit_valid | output | 1 | Strobe for a captured bit |
| bit_data | output | 1 | Captured teletext bit |
| count_err | output | 1 | Sticky request/capture count mismatch |

## Verification
The embedded properties assume that `line_start` pulses are at least a few clocks apart. The minimum request spacing of three clocks therefore holds across a line boundary. They also assume that the source's data timing is exactly four clocks, so at most LAT bits can be outstanding unless the count error has already fired. The stimulus keeps every full line at 400 clocks, well past the window end plus the capture delay, and changes `pal_mode` and the line range only together with a line start. The single short line is cut deliberately one request before a capture lands, so that the count mismatch is provoked under control.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
   // Inclusive line-range test used for the per-line enable.
   function automatic logic line_in_range(input logic [15:0] num,
                                          input logic [15:0] lo,
                                          input logic [15:0] hi);
      return (num >= lo) && (num <= hi);
   endfunction
endpackage

// File: rtl/ttx_pacer.sv
module ttx_pacer #(
   parameter int BITS    = 37,
   parameter int CLKS    = 144,
   parameter int H_START = 32,
   parameter int GROUPS  = 2,
   parameter int HCNT_W  = 11,
   parameter int LINE_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pal_mode,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic [LINE_W-1:0] first_line,
   input  logic [LINE_W-1:0] last_line,
   output logic              req
);
   localparam int WIN_LEN = CLKS * GROUPS;
   localparam int H_END   = H_START + WIN_LEN;
   localparam int ACC_W   = $clog2(CLKS + BITS + 1);
   localparam logic [HCNT_W-1:0] HMAX = '1;

   generate
      if (BITS >= CLKS || BITS < 1) begin : g_bad_ratio
         $error("ttx_pacer: BITS must lie in 1..CLKS-1");
      end
      if (H_END >= (1 << HCNT_W)) begin : g_bad_hcnt
         $error("ttx_pacer: HCNT_W too small for the window");
      end
      if (LINE_W > 16) begin : g_bad_line
         $error("ttx_pacer: LINE_W limited to 16");
      end
   endgenerate

   logic [HCNT_W-1:0] hcnt;
   logic              line_ok;
   logic [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]  acc_sum;
   logic              in_win;

   assign acc_sum = acc + ACC_W'(BITS);
   assign in_win  = line_ok && pal_mode &&
                    (hcnt >= HCNT_W'(H_START)) && (hcnt < HCNT_W'(H_END));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt    <= HMAX;
         line_ok <= 1'b0;
      end else if (line_start) begin
         hcnt    <= '0;
         line_ok <= pal_mode &&
                    ttx_pkg::line_in_range(16'(line_num), 16'(first_line), 16'(last_line));
      end else if (hcnt != HMAX) begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || line_start) begin
         acc <= '0;
         req <= 1'b0;
      end else if (in_win) begin
         if (acc_sum >= ACC_W'(CLKS)) begin
            acc <= acc_sum - ACC_W'(CLKS);
            req <= 1'b1;
         end else begin
            acc <= acc_sum;
            req <= 1'b0;
         end
      end else begin
         req <= 1'b0;
      end
   end

   // Requests are never closer than three clocks apart.
   assert_req_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
   assert_req_spacing2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ##1 !req);
   // Outside the window (horizontal count beyond its end) no request follows.
   assert_no_req_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && hcnt > HCNT_W'(H_END)) |=> !req);
endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
   parameter int LAT    = 4,
   parameter int MAXCNT = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic req,
   input  logic ttx_in,
   output logic bit_valid,
   output logic bit_data,
   output logic count_err
);
   localparam int CNT_W = $clog2(MAXCNT + LAT + 2) + 1;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("ttx_capture: LAT must be at least 1");
      end
   endgenerate

   logic [LAT-1:0]   dly;
   logic             cap_ev;
   logic [CNT_W-1:0] req_cnt;
   logic [CNT_W-1:0] cap_cnt;

   // Request flags travel down a delay line matching the source latency.
   always_ff @(posedge clk) begin
      if (!rst_n) dly[0] <= 1'b0;
      else        dly[0] <= req;
   end
   genvar gi;
   generate
      for (gi = 1; gi < LAT; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) dly[gi] <= 1'b0;
            else        dly[gi] <= dly[gi-1];
         end
      end
   endgenerate
   assign cap_ev = dly[LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_data  <= 1'b0;
      end else begin
         bit_valid <= cap_ev;
         if (cap_ev) bit_data <= ttx_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_cnt   <= '0;
         cap_cnt   <= '0;
         count_err <= 1'b0;
      end else if (line_start) begin
         if (req_cnt != cap_cnt) count_err <= 1'b1;
         req_cnt <= CNT_W'(req);
         cap_cnt <= CNT_W'(cap_ev);
      end else begin
         if (req)    req_cnt <= req_cnt + 1'b1;
         if (cap_ev) cap_cnt <= cap_cnt + 1'b1;
      end
   end

   // Strobes are single-cycle because requests are spaced.
   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);
   // Never more than LAT bits outstanding while counts are consistent.
   assert_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n || count_err)
      (cap_cnt <= req_cnt) && ((req_cnt - cap_cnt) <= CNT_W'(LAT)));
   // The error flag is sticky.
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count_err |=> count_err);
endmodule

// File: rtl/ttx_req_seq.sv
module ttx_req_seq #(
   parameter int BITS    = 37,
   parameter int CLKS    = 144,
   parameter int LAT     = 4,
   parameter int H_START = 32,
   parameter int GROUPS  = 2,
   parameter int HCNT_W  = 11,
   parameter int LINE_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pal_mode,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic [LINE_W-1:0] first_line,
   input  logic [LINE_W-1:0] last_line,
   output logic              ttx_req,
   input  logic              ttx_in,
   output logic              bit_valid,
   output logic              bit_data,
   output logic              count_err
);
   localparam int BITS_PER_LINE = BITS * GROUPS;

   ttx_pacer #(
      .BITS(BITS), .CLKS(CLKS), .H_START(H_START), .GROUPS(GROUPS),
      .HCNT_W(HCNT_W), .LINE_W(LINE_W)
   ) u_pacer (
      .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .line_start(line_start),
      .line_num(line_num), .first_line(first_line), .last_line(last_line),
      .req(ttx_req)
   );

   ttx_capture #(.LAT(LAT), .MAXCNT(BITS_PER_LINE)) u_cap (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .req(ttx_req),
      .ttx_in(ttx_in), .bit_valid(bit_valid), .bit_data(bit_data),
      .count_err(count_err)
   );

   // A low standard select in the previous cycle forbids a request now.
   assert_pal_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pal_mode |=> !ttx_req);
   // The cycle after reset release starts quiet.
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!ttx_req && !bit_valid && !count_err));
endmodule

// File: tb/ttx_req_seq_test.sv
module ttx_req_seq_test;
   localparam int BITS = 37, CLKS = 144, LAT = 4, H_START = 32, GROUPS = 2;
   localparam int LINE_W = 10;
   localparam int FULL = BITS * GROUPS;

   logic clk = 0, rst_n = 0, pal_mode = 0, line_start = 0, ttx_in = 0;
   logic [LINE_W-1:0] line_num = '0, first_line = 10'd5, last_line = 10'd6;
   logic ttx_req, bit_valid, bit_data, count_err;

   ttx_req_seq #(.BITS(BITS), .CLKS(CLKS), .LAT(LAT), .H_START(H_START),
                 .GROUPS(GROUPS), .LINE_W(LINE_W)) uut (
      .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .line_start(line_start),
      .line_num(line_num), .first_line(first_line), .last_line(last_line),
      .ttx_req(ttx_req), .ttx_in(ttx_in), .bit_valid(bit_valid),
      .bit_data(bit_data), .count_err(count_err));

   always #10 clk = ~clk;

   int tests = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expectations set by the driver together with each line start.
   bit  drv_on = 0;
   int  drv_total = 0;
   // Monitor state.
   bit  mon_on = 0, have_prev = 0, in_reset = 1;
   int  mon_total = 0, lstart = 0, nreq = 0;
   bit  sched_v [8];
   bit  sched_b [8];
   bit  exp_q [$];

   always @(negedge clk) begin
      if (in_reset) begin
         nreq = 0; have_prev = 0;
         exp_q.delete();
         for (int i = 0; i < 8; i++) sched_v[i] = 0;
      end else begin
         // Scoreboard side: compare captured bits in order (R5).
         if (bit_valid) begin
            if (exp_q.size() == 0) chk(0, "R5 strobe without request", 1, 0);
            else begin
               automatic bit e = exp_q.pop_front();
               chk(bit_data == e, "R5 captured bit", bit_data, e);
            end
         end
         if (line_start) begin
            if (have_prev && mon_total >= 0)
               chk(nreq == mon_total, "R3 requests per line", nreq, mon_total);
            have_prev = 1; mon_on = drv_on; mon_total = drv_total;
            lstart = cyc; nreq = 0;
         end
         if (ttx_req) begin
            automatic int k = cyc - lstart - 2 - H_START;
            automatic int n = nreq + 1;
            automatic int ek = (CLKS * n + BITS - 1) / BITS - 1;
            if (!mon_on) chk(0, "R3/R4 request on disabled line", k, -1);
            else chk(k == ek && n <= FULL, "R2 request position", k, ek);
            nreq = n;
            sched_v[(cyc + LAT) % 8] = 1;
            sched_b[(cyc + LAT) % 8] = 1'($urandom);
         end
      end
      // Drive the source for this cycle.
      if (!in_reset && sched_v[cyc % 8]) begin
         ttx_in = sched_b[cyc % 8];
         exp_q.push_back(sched_b[cyc % 8]);
         sched_v[cyc % 8] = 0;
      end else begin
         ttx_in = 1'($urandom);
      end
   end

   task automatic run_line(input int num, input int len, input bit pal,
                           input bit skip_total);
      @(posedge clk); #1;
      pal_mode = pal; line_num = LINE_W'(num); line_start = 1;
      drv_on = pal && num >= 5 && num <= 6;
      drv_total = skip_total ? -1 : (drv_on ? FULL : 0);
      @(posedge clk); #1;
      line_start = 0;
      repeat (len - 2) @(posedge clk);
   endtask

   task automatic do_reset();
      in_reset = 1; rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!ttx_req, "R1 req in reset", ttx_req, 0);
      chk(!bit_valid, "R1 valid in reset", bit_valid, 0);
      chk(!count_err, "R1 err in reset", count_err, 0);
      @(posedge clk); #1 rst_n = 1;
      @(negedge clk); in_reset = 0;
      chk(!ttx_req && !bit_valid && !count_err, "R1 after reset", count_err, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      run_line(3, 400, 1, 0);          // R3: outside range
      run_line(5, 400, 1, 0);          // R2: enabled
      run_line(6, 400, 1, 0);          // R2: enabled
      run_line(7, 400, 1, 0);          // R3: outside range
      run_line(5, 400, 0, 0);          // R4: standard not PAL
      run_line(6, 400, 1, 0);
      run_line(8, 400, 1, 0);
      @(negedge clk);
      chk(!count_err, "R7 no error on full lines", count_err, 0);
      run_line(6, 39, 1, 1);           // cut with one bit in flight
      run_line(9, 400, 1, 0);
      @(negedge clk);
      chk(count_err, "R6 mismatch flagged", count_err, 1);
      run_line(5, 400, 1, 0);
      run_line(6, 400, 1, 0);
      run_line(4, 400, 1, 0);
      @(negedge clk);
      chk(count_err, "R8 error stays set", count_err, 1);
      chk(exp_q.size() == 0, "R5 all bits delivered", exp_q.size(), 0);
      do_reset();
      chk(!count_err, "R8 cleared only by reset", count_err, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule